// File: doc/BRIEF.md
# Plug-and-play ISA card configuration controller

This block is the card-side control logic for a plug-and-play expansion card on a simplified, synchronous ISA I/O bus. The host talks to it through three ports. It writes a register index to a fixed index port at 0x279. It then either writes a value to a fixed data port at 0xA79 or reads from a read port whose location software chooses. The block holds the card-level operating mode, the card select number (CSN), the selected logical device, the read-port location, the serial-identifier bit position and the resource-byte position. It also carries out the card-level commands.

A freshly reset card stays dormant until the host writes a 32-byte unlock sequence to the index port. The card then sleeps. A wake command either starts serial isolation, in which competing cards compare identifier bits one at a time, or opens configuration for one card. In configuration the host reads descriptor bytes from a small on-chip table through a ready/fetch handshake. The per-device resource registers and external storage sit outside this block. The block only pulses a reset request toward them.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset, `card_state_o` is 0 (dormant), `csn_o` is 0, `ldev_sel_o` is 0, `ldev_reset_o` is 0, and the read port sits at I/O address 0x003. The mode encoding is 0 dormant, 1 sleeping, 2 isolating, 3 configuring.
- R2: In the dormant mode, writes to 0x279 are compared against the unlock sequence. Entry 0 is KEY_SEED (0x6A), and each following entry is `{e[0]^e[1], e[7:1]}` of the one before. The write that completes all KEY_LEN entries in order moves the card to sleeping on that clock edge. A mismatched byte restarts the comparison at entry 0 and is not itself taken as entry 0. Writes to 0xA79 have no effect while dormant.
- R3: A data write to index 0x00 in any non-dormant mode moves the read port to address `{2'b00, data, 2'b11}`. Reads at any other address are never driven. A read of index 0x00 is not driven.
- R4: A data write to index 0x02 acts through its bits in the same write. Bit 0 pulses `ldev_reset_o` high for exactly one cycle and keeps the CSN. Bit 2 clears the CSN to 0. Bit 1 returns the card to dormant and keeps the CSN. Reads of index 0x02 are not driven.
- R5: A data write to index 0x03 whose value equals the CSN sends the card to isolating when the value is 0 and to configuring otherwise. It also rewinds the identifier bit position and the resource position to 0. A non-matching value sends an isolating or configuring card to sleeping and leaves a sleeping card unchanged.
- R6: While isolating, each read of index 0x01 consumes the next serial-identifier bit, least significant first. A 1 bit drives 0x55. A 0 bit drives nothing, and if `io_sense` shows 0x55 on that read, the card drops to sleeping. The card drives the bus only while isolating or configuring.
- R7: Once all ID_BITS bits have been read while isolating, a data write to index 0x06 stores the value as the CSN and moves the card to configuring. Before that point the write is ignored. In configuring, index 0x06 is read/write.
- R8: Resource byte k equals `(k*RES_MUL + RES_ADD) mod 256`. After a wake, or after a byte is taken, the ready flag rises on the second clock edge. A read of index 0x04 while ready returns byte k, clears ready and advances k, wrapping after RES_DEPTH bytes. A read while not ready returns 0x00 and does not advance.
- R9: In configuring, a read of index 0x05 returns `{7'b0, ready}`.
- R10: In configuring, a data write to index 0x07 below NUM_LDEV selects that logical device, and the selection reads back at index 0x07. A value of NUM_LDEV or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 12 | I/O address of the current cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_sense | input | 8 | Value seen on the shared data bus during a read |
| io_rdata | output | 8 | Read data, 0 when not driven |
| io_rdata_oe | output | 1 | Card drives the data bus this cycle |
| card_state_o | output | 2 | Card mode (0 dormant, 1 sleeping, 2 isolating, 3 configuring) |
| csn_o | output | 8 | Card select number |
| ldev_sel_o | output | LDW | Selected logical device |
| ldev_reset_o | output | 1 | One-cycle reset request to the logical devices |

## Verification
A wrong mode shows at once on `card_state_o`. It also shows in the same read cycle as a driven or silent data bus that disagrees with the reference. A stale key position or identifier bit position appears only later, when the final key byte fails to wake the card or a 0x55 appears on the wrong bit. For that reason the bench walks every bit and every key byte. A resource position that is off by one, or a ready flag that rises a cycle early, shows on the next status or data read. The bench therefore polls status and compares each byte against the formula.

// File: rtl/pnp_card_pkg.sv
// Shared types and constants for the plug-and-play card controller.
// Assumes a 12-bit I/O address and byte-wide data.
package pnp_card_pkg;

    typedef enum logic [1:0] {
        ST_DORMANT  = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_ISOLATE  = 2'd2,
        ST_CONFIG   = 2'd3
    } card_state_t;

    localparam logic [11:0] INDEX_PORT = 12'h279;
    localparam logic [11:0] DATA_PORT  = 12'hA79;

    localparam logic [7:0] IX_RDPORT  = 8'h00;
    localparam logic [7:0] IX_ISOBIT  = 8'h01;
    localparam logic [7:0] IX_CTRL    = 8'h02;
    localparam logic [7:0] IX_WAKE    = 8'h03;
    localparam logic [7:0] IX_RESBYTE = 8'h04;
    localparam logic [7:0] IX_STATUS  = 8'h05;
    localparam logic [7:0] IX_CSN     = 8'h06;
    localparam logic [7:0] IX_LDEV    = 8'h07;

    // Next entry of the unlock sequence.
    function automatic logic [7:0] key_step(input logic [7:0] b);
        return {b[0] ^ b[1], b[7:1]};
    endfunction

    // Resource table entry k, computed rather than stored.
    function automatic logic [7:0] res_entry(input int unsigned k,
                                             input int unsigned mul,
                                             input int unsigned add);
        int unsigned v;
        v = k * mul + add;
        return v[7:0];
    endfunction

endpackage

// File: rtl/pnp_key_detect.sv
// Unlock-sequence detector. Compares index-port writes against a running
// LFSR sequence seeded with KEY_SEED. Assumes arm_i is high only while the
// card is dormant; dropping arm_i rewinds the comparison.
module pnp_key_detect
    import pnp_card_pkg::*;
#(
    parameter int          KEY_LEN  = 32,
    parameter logic [7:0]  KEY_SEED = 8'h6A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  logic       wr_i,
    input  logic [7:0] byte_i,
    output logic       done_o
);
    localparam int PW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(KEY_LEN - 1);

    logic [PW-1:0] pos_q;
    logic [7:0]    expect_q;
    logic          match;

    assign match  = wr_i && (byte_i == expect_q);
    assign done_o = arm_i && match && (pos_q == LAST);

    // Track position and expected byte; any mismatch rewinds to entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i) begin
            pos_q    <= '0;
            expect_q <= KEY_SEED;
        end else if (wr_i) begin
            if (match && pos_q != LAST) begin
                pos_q    <= pos_q + 1'b1;
                expect_q <= key_step(expect_q);
            end else begin
                pos_q    <= '0;
                expect_q <= KEY_SEED;
            end
        end
    end

endmodule

// File: rtl/pnp_isolation.sv
// Serial-identifier walker for isolation. Each rd_bit_i consumes one bit,
// LSB first. A card whose bit is 0 loses when the bus shows 0x55.
// Assumes rd_bit_i is only raised while the card is isolating.
module pnp_isolation #(
    parameter int                 ID_BITS   = 72,
    parameter logic [ID_BITS-1:0] SERIAL_ID = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       rd_bit_i,
    input  logic [7:0] sense_i,
    output logic       bit_o,
    output logic       won_o,
    output logic       lose_o
);
    localparam int CW = $clog2(ID_BITS + 1);

    logic [CW-1:0] cnt_q;

    assign won_o  = (cnt_q == CW'(ID_BITS));
    assign bit_o  = won_o ? 1'b0 : SERIAL_ID[cnt_q];
    assign lose_o = rd_bit_i && !won_o && !bit_o && (sense_i == 8'h55);

    // Advance the bit position on each comparison read until all are used.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (rd_bit_i && !won_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pnp_resource_reader.sv
// Resource byte sequencer. After restart or take, fetches the entry at the
// pointer on the next edge and raises ready one edge later. Assumes take_i
// is only raised while ready_o is high.
module pnp_resource_reader
    import pnp_card_pkg::*;
#(
    parameter int RES_DEPTH = 16,
    parameter int RES_MUL   = 37,
    parameter int RES_ADD   = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       take_i,
    output logic       ready_o,
    output logic [7:0] byte_o
);
    localparam int PW = (RES_DEPTH > 1) ? $clog2(RES_DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(RES_DEPTH - 1);

    logic [PW-1:0] ptr_q;
    logic          fetch_q;
    logic          landed_q;
    logic          ready_q;
    logic [7:0]    data_q;

    assign ready_o = ready_q;
    assign byte_o  = data_q;

    // Pointer, two-step fetch and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            fetch_q  <= 1'b0;
            landed_q <= 1'b0;
            ready_q  <= 1'b0;
            data_q   <= 8'h00;
        end else if (restart_i) begin
            ptr_q    <= '0;
            fetch_q  <= 1'b1;
            landed_q <= 1'b0;
            ready_q  <= 1'b0;
        end else if (take_i) begin
            ptr_q    <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            fetch_q  <= 1'b1;
            landed_q <= 1'b0;
            ready_q  <= 1'b0;
        end else begin
            if (fetch_q) begin
                data_q   <= res_entry(32'(ptr_q), RES_MUL, RES_ADD);
                fetch_q  <= 1'b0;
                landed_q <= 1'b1;
            end
            if (landed_q) begin
                ready_q  <= 1'b1;
                landed_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pnp_card_ctrl.sv
// Card-level control for a plug-and-play ISA card: port decode, mode
// machine, CSN, logical-device select and command execution.
// Assumes single-cycle, mutually exclusive io_wr / io_rd strobes.
module pnp_card_ctrl
    import pnp_card_pkg::*;
#(
    parameter int                 KEY_LEN   = 32,
    parameter logic [7:0]         KEY_SEED  = 8'h6A,
    parameter int                 ID_BITS   = 72,
    parameter logic [ID_BITS-1:0] SERIAL_ID = 72'h12_3456_789A_BCDE_F05A,
    parameter int                 RES_DEPTH = 16,
    parameter int                 RES_MUL   = 37,
    parameter int                 RES_ADD   = 11,
    parameter int                 NUM_LDEV  = 2,
    localparam int                LDW       = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [11:0]    io_addr,
    input  logic           io_wr,
    input  logic           io_rd,
    input  logic [7:0]     io_wdata,
    input  logic [7:0]     io_sense,
    output logic [7:0]     io_rdata,
    output logic           io_rdata_oe,
    output logic [1:0]     card_state_o,
    output logic [7:0]     csn_o,
    output logic [LDW-1:0] ldev_sel_o,
    output logic           ldev_reset_o
);
    card_state_t state_q, state_d;
    logic [7:0]  idx_q;
    logic [7:0]  csn_q, csn_d;
    logic [7:0]  rdport_q;
    logic        ldrst_q;

    logic        dormant, live_rd;
    logic        idx_hit, data_hit, rd_hit;
    logic        key_wr, dwr, drd;
    logic        key_done;
    logic        wake_hit;
    logic        iso_rd, iso_bit, iso_won, iso_lose;
    logic        res_take, res_ready;
    logic [7:0]  res_byte;
    logic        ldev_wr;
    logic [7:0]  ldev_rd;
    logic        rd_oe;
    logic [7:0]  rd_val;

    // Port decode.
    assign dormant  = (state_q == ST_DORMANT);
    assign live_rd  = (state_q == ST_ISOLATE) || (state_q == ST_CONFIG);
    assign idx_hit  = (io_addr == INDEX_PORT);
    assign data_hit = (io_addr == DATA_PORT);
    assign rd_hit   = (io_addr == {2'b00, rdport_q, 2'b11});
    assign key_wr   = io_wr && idx_hit && dormant;
    assign dwr      = io_wr && data_hit && !dormant;
    assign drd      = io_rd && rd_hit && live_rd;

    assign wake_hit = dwr && (idx_q == IX_WAKE) && (io_wdata == csn_q);
    assign iso_rd   = drd && (idx_q == IX_ISOBIT) && (state_q == ST_ISOLATE);
    assign res_take = drd && (idx_q == IX_RESBYTE) && (state_q == ST_CONFIG) && res_ready;
    assign ldev_wr  = dwr && (idx_q == IX_LDEV) && (state_q == ST_CONFIG);

    pnp_key_detect #(
        .KEY_LEN  (KEY_LEN),
        .KEY_SEED (KEY_SEED)
    ) key_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (dormant),
        .wr_i   (key_wr),
        .byte_i (io_wdata),
        .done_o (key_done)
    );

    pnp_isolation #(
        .ID_BITS   (ID_BITS),
        .SERIAL_ID (SERIAL_ID)
    ) iso_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (wake_hit),
        .rd_bit_i  (iso_rd),
        .sense_i   (io_sense),
        .bit_o     (iso_bit),
        .won_o     (iso_won),
        .lose_o    (iso_lose)
    );

    pnp_resource_reader #(
        .RES_DEPTH (RES_DEPTH),
        .RES_MUL   (RES_MUL),
        .RES_ADD   (RES_ADD)
    ) res_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (wake_hit),
        .take_i    (res_take),
        .ready_o   (res_ready),
        .byte_o    (res_byte)
    );

    // Logical-device select: a register when several devices exist.
    generate
        if (NUM_LDEV > 1) begin : g_multi_ldev
            logic [LDW-1:0] sel_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel_q <= '0;
                end else if (ldev_wr && (io_wdata < 8'(NUM_LDEV))) begin
                    sel_q <= io_wdata[LDW-1:0];
                end
            end
            assign ldev_sel_o = sel_q;
            assign ldev_rd    = 8'(sel_q);
        end else begin : g_single_ldev
            logic unused_wr;
            assign unused_wr  = ldev_wr;
            assign ldev_sel_o = '0;
            assign ldev_rd    = 8'h00;
        end
    endgenerate

    // Next mode and CSN from commands, isolation loss and unlock.
    always_comb begin
        state_d = state_q;
        csn_d   = csn_q;
        if (key_done) state_d = ST_SLEEP;
        if (iso_lose) state_d = ST_SLEEP;
        if (dwr) begin
            case (idx_q)
                IX_CTRL: begin
                    if (io_wdata[2]) csn_d = 8'h00;
                    if (io_wdata[1]) state_d = ST_DORMANT;
                end
                IX_WAKE: begin
                    if (io_wdata == csn_q) begin
                        state_d = (io_wdata == 8'h00) ? ST_ISOLATE : ST_CONFIG;
                    end else if (live_rd) begin
                        state_d = ST_SLEEP;
                    end
                end
                IX_CSN: begin
                    if (state_q == ST_ISOLATE && iso_won) begin
                        csn_d   = io_wdata;
                        state_d = ST_CONFIG;
                    end else if (state_q == ST_CONFIG) begin
                        csn_d = io_wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // Card-level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_DORMANT;
            csn_q    <= 8'h00;
            idx_q    <= 8'h00;
            rdport_q <= 8'h00;
            ldrst_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            csn_q   <= csn_d;
            ldrst_q <= dwr && (idx_q == IX_CTRL) && io_wdata[0];
            if (io_wr && idx_hit && !dormant) idx_q <= io_wdata;
            if (dwr && idx_q == IX_RDPORT) rdport_q <= io_wdata;
        end
    end

    // Read-data mux for the programmable read port.
    always_comb begin
        rd_oe  = 1'b0;
        rd_val = 8'h00;
        if (drd) begin
            case (idx_q)
                IX_ISOBIT: begin
                    if (state_q == ST_ISOLATE && !iso_won && iso_bit) begin
                        rd_oe  = 1'b1;
                        rd_val = 8'h55;
                    end
                end
                IX_RESBYTE: begin
                    if (state_q == ST_CONFIG) begin
                        rd_oe  = 1'b1;
                        rd_val = res_ready ? res_byte : 8'h00;
                    end
                end
                IX_STATUS: begin
                    if (state_q == ST_CONFIG) begin
                        rd_oe  = 1'b1;
                        rd_val = {7'b0, res_ready};
                    end
                end
                IX_CSN: begin
                    if (state_q == ST_CONFIG) begin
                        rd_oe  = 1'b1;
                        rd_val = csn_q;
                    end
                end
                IX_LDEV: begin
                    if (state_q == ST_CONFIG) begin
                        rd_oe  = 1'b1;
                        rd_val = ldev_rd;
                    end
                end
                default: ;
            endcase
        end
    end

    assign io_rdata     = rd_val;
    assign io_rdata_oe  = rd_oe;
    assign card_state_o = state_q;
    assign csn_o        = csn_q;
    assign ldev_reset_o = ldrst_q;

endmodule

// File: rtl/pnp_card_ctrl_chk.sv
// Property checker for pnp_card_ctrl, attached by bind. Watches ports and
// the resource handshake; assumes synchronous active-low reset.
module pnp_card_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] card_state_o,
    input logic [7:0] csn_o,
    input logic [7:0] io_rdata,
    input logic       io_rdata_oe,
    input logic       ldev_reset_o,
    input logic       res_ready,
    input logic       res_take
);
    // R1: first cycle out of reset shows the dormant mode and CSN 0.
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (card_state_o == 2'd0 && csn_o == 8'h00 && !io_rdata_oe));

    // R2: leaving the dormant mode always lands in sleeping.
    a_r2_unlock_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(card_state_o) == 2'd0 && card_state_o != 2'd0) |-> card_state_o == 2'd1);

    // R4: the logical-device reset request lasts one cycle.
    a_r4_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ldev_reset_o |=> !ldev_reset_o);

    // R6: a dormant or sleeping card never drives the bus.
    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (card_state_o == 2'd0 || card_state_o == 2'd1) |-> !io_rdata_oe);

    // R6: while isolating, the only driven value is 0x55.
    a_r6_isolation_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rdata_oe && card_state_o == 2'd2) |-> io_rdata == 8'h55);

    // R7: configuring is entered only from sleeping or isolating.
    a_r7_config_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(card_state_o) != 2'd3 && card_state_o == 2'd3) |->
            ($past(card_state_o) == 2'd1 || $past(card_state_o) == 2'd2));

    // R8: taking a byte drops ready on the next cycle.
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        res_take |=> !res_ready);

endmodule

bind pnp_card_ctrl pnp_card_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .card_state_o (card_state_o),
    .csn_o        (csn_o),
    .io_rdata     (io_rdata),
    .io_rdata_oe  (io_rdata_oe),
    .ldev_reset_o (ldev_reset_o),
    .res_ready    (res_ready),
    .res_take     (res_take)
);

// File: tb/pnp_card_ctrl_tb.sv
// Bench: behavioural reference model stepped with the stimulus and compared
// against the design on every clock.
module pnp_card_ctrl_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          KEY_LEN    = 32;
    localparam logic [7:0]  KEY_SEED   = 8'h6A;
    localparam int          ID_BITS    = 72;
    localparam logic [71:0] SID        = 72'h12_3456_789A_BCDE_F05A;
    localparam int          RES_DEPTH  = 16;
    localparam int          RES_MUL    = 37;
    localparam int          RES_ADD    = 11;
    localparam int          NUM_LDEV   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_sense = '0;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic [1:0]  card_state_o;
    logic [7:0]  csn_o;
    logic [0:0]  ldev_sel_o;
    logic        ldev_reset_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pnp_card_ctrl #(
        .KEY_LEN(KEY_LEN), .KEY_SEED(KEY_SEED), .ID_BITS(ID_BITS), .SERIAL_ID(SID),
        .RES_DEPTH(RES_DEPTH), .RES_MUL(RES_MUL), .RES_ADD(RES_ADD), .NUM_LDEV(NUM_LDEV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_sense(io_sense), .io_rdata(io_rdata),
        .io_rdata_oe(io_rdata_oe), .card_state_o(card_state_o), .csn_o(csn_o),
        .ldev_sel_o(ldev_sel_o), .ldev_reset_o(ldev_reset_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_req = "R1";
    logic [7:0] key_q[$];
    logic [7:0] last_rd;
    logic       last_oe;
    logic [11:0] rd_addr = 12'h003;

    // Reference model
    int m_st = 0, m_csn = 0, m_rdport = 0, m_idx = 0, m_kpos = 0;
    int m_bit = 0, m_ptr = 0, m_wait = 0, m_ldev = 0;
    bit m_primed = 0, m_ldrst = 0;

    function automatic bit m_ready();
        return m_primed && (m_wait == 0);
    endfunction

    function automatic int rom(int k);
        return (k * RES_MUL + RES_ADD) % 256;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_read(input logic [11:0] a, input logic r,
                              output bit oe, output int val);
        oe = 0; val = 0;
        if (r && a == {2'b00, m_rdport[7:0], 2'b11} && m_st >= 2) begin
            case (m_idx)
                1: if (m_st == 2 && m_bit < ID_BITS && SID[m_bit]) begin oe = 1; val = 8'h55; end
                4: if (m_st == 3) begin oe = 1; val = m_ready() ? rom(m_ptr) : 0; end
                5: if (m_st == 3) begin oe = 1; val = int'(m_ready()); end
                6: if (m_st == 3) begin oe = 1; val = m_csn; end
                7: if (m_st == 3) begin oe = 1; val = m_ldev; end
                default: ;
            endcase
        end
    endtask

    task automatic model_edge(input logic [11:0] a, input logic w, input logic r,
                              input logic [7:0] d, input logic [7:0] s);
        int nst = m_st, ncsn = m_csn, nkpos = m_kpos, nidx = m_idx;
        int nbit = m_bit, nport = m_rdport, nldev = m_ldev;
        bit wfk = (m_st == 0);
        bit rdhit = r && a == {2'b00, m_rdport[7:0], 2'b11} && m_st >= 2;
        bit restart = 0, take = 0;
        if (!wfk) nkpos = 0;
        if (w && a == 12'h279) begin
            if (wfk) begin
                if (d == key_q[m_kpos]) begin
                    if (m_kpos == KEY_LEN - 1) begin nkpos = 0; nst = 1; end
                    else nkpos = m_kpos + 1;
                end else nkpos = 0;
            end else nidx = d;
        end
        m_ldrst = 0;
        if (w && a == 12'hA79 && !wfk) begin
            case (m_idx)
                0: nport = d;
                2: begin
                    if (d[0]) m_ldrst = 1;
                    if (d[2]) ncsn = 0;
                    if (d[1]) nst = 0;
                end
                3: if (int'(d) == m_csn) begin nst = (d == 0) ? 2 : 3; restart = 1; end
                   else if (m_st >= 2) nst = 1;
                6: if (m_st == 2 && m_bit == ID_BITS) begin ncsn = d; nst = 3; end
                   else if (m_st == 3) ncsn = d;
                7: if (m_st == 3 && d < NUM_LDEV) nldev = d;
                default: ;
            endcase
        end
        if (rdhit && m_idx == 1 && m_st == 2 && m_bit < ID_BITS) begin
            if (!SID[m_bit] && s == 8'h55) nst = 1;
            nbit = m_bit + 1;
        end
        if (rdhit && m_idx == 4 && m_st == 3 && m_ready()) take = 1;
        if (restart) begin
            nbit = 0; m_ptr = 0; m_wait = 2; m_primed = 1;
        end else if (take) begin
            m_ptr = (m_ptr + 1) % RES_DEPTH; m_wait = 2;
        end else if (m_wait > 0) m_wait--;
        m_st = nst; m_csn = ncsn; m_kpos = nkpos; m_idx = nidx;
        m_bit = nbit; m_rdport = nport; m_ldev = nldev;
    endtask

    // One bus cycle: drive, compare read path, clock, compare state.
    task automatic cyc(input logic [11:0] a, input logic w, input logic r,
                       input logic [7:0] d, input logic [7:0] s);
        bit eoe; int erd;
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d; io_sense = s;
        #1;
        model_read(a, r, eoe, erd);
        last_rd = io_rdata; last_oe = io_rdata_oe;
        chk(io_rdata_oe == eoe, cur_req, "rdata_oe", int'(io_rdata_oe), int'(eoe));
        chk(int'(io_rdata) == erd, cur_req, "rdata", int'(io_rdata), erd);
        @(posedge clk);
        model_edge(a, w, r, d, s);
        #1;
        chk(int'(card_state_o) == m_st, cur_req, "state", int'(card_state_o), m_st);
        chk(int'(csn_o) == m_csn, cur_req, "csn", int'(csn_o), m_csn);
        chk(int'(ldev_sel_o) == m_ldev, cur_req, "ldev", int'(ldev_sel_o), m_ldev);
        chk(ldev_reset_o == m_ldrst, cur_req, "ldev_reset", int'(ldev_reset_o), int'(m_ldrst));
    endtask

    task automatic idle();                      cyc(12'h000, 0, 0, 8'h00, 8'h00); endtask
    task automatic set_idx(input logic [7:0] v); cyc(12'h279, 1, 0, v, 8'h00); endtask
    task automatic wdat(input logic [7:0] v);    cyc(12'hA79, 1, 0, v, 8'h00); endtask
    task automatic rdp(input logic [7:0] s);     cyc(rd_addr, 0, 1, 8'h00, s); endtask

    task automatic send_key();
        foreach (key_q[i]) cyc(12'h279, 1, 0, key_q[i], 8'h00);
    endtask

    // Poll status until ready, then take one resource byte and compare.
    task automatic take_byte(input int k);
        set_idx(8'h05);
        for (int t = 0; t < 8; t++) begin
            rdp(8'h00);
            if (last_rd[0]) break;
        end
        chk(last_rd == 8'h01, "R9", "status ready", int'(last_rd), 1);
        set_idx(8'h04);
        rdp(8'h00);
        chk(int'(last_rd) == rom(k % RES_DEPTH), "R8", "resource byte", int'(last_rd), rom(k % RES_DEPTH));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] k;
        k = KEY_SEED;
        for (int i = 0; i < KEY_LEN; i++) begin key_q.push_back(k); k = {k[0] ^ k[1], k[7:1]}; end

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        chk(card_state_o == 2'd0, "R1", "reset state", int'(card_state_o), 0);
        chk(csn_o == 8'h00, "R1", "reset csn", int'(csn_o), 0);
        chk(!ldev_reset_o && ldev_sel_o == 1'b0, "R1", "reset ldev", int'(ldev_sel_o), 0);
        cur_req = "R1"; rdp(8'h00);

        // R2: dormant ignores data port; mismatch restarts; full key unlocks
        cur_req = "R2";
        wdat(8'h99);
        cyc(12'h279, 1, 0, key_q[0], 8'h00);
        cyc(12'h279, 1, 0, key_q[1], 8'h00);
        cyc(12'h279, 1, 0, 8'h00, 8'h00);
        cyc(12'h279, 1, 0, key_q[2], 8'h00);
        chk(card_state_o == 2'd0, "R2", "still dormant after broken key", int'(card_state_o), 0);
        send_key();
        chk(card_state_o == 2'd1, "R2", "sleep after key", int'(card_state_o), 1);

        // R3: move the read port to 0x203
        cur_req = "R3";
        set_idx(8'h00); wdat(8'h80); rd_addr = 12'h203;
        // R5: wake with 5 while CSN 0 is ignored in sleep; wake 0 isolates
        cur_req = "R5";
        set_idx(8'h03); wdat(8'h05);
        chk(card_state_o == 2'd1, "R5", "non-matching wake in sleep", int'(card_state_o), 1);
        wdat(8'h00);
        chk(card_state_o == 2'd2, "R5", "wake 0 isolates", int'(card_state_o), 2);

        // R3: old port silent; R6 walk all bits with quiet bus
        cur_req = "R3";
        set_idx(8'h01);
        cyc(12'h003, 0, 1, 8'h00, 8'h00);
        chk(!last_oe, "R3", "old read port silent", int'(last_oe), 0);
        cur_req = "R6";
        rdp(8'h00);
        chk(!last_oe, "R6", "bit0 zero not driven", int'(last_oe), 0);
        rdp(8'h00);
        chk(last_oe && last_rd == 8'h55, "R6", "bit1 one drives 55", int'(last_rd), 8'h55);
        cur_req = "R7";
        set_idx(8'h06); wdat(8'h05);
        chk(card_state_o == 2'd2 && csn_o == 8'h00, "R7", "early CSN ignored", int'(csn_o), 0);
        set_idx(8'h01);
        cur_req = "R6";
        for (int b = 2; b < ID_BITS; b++) rdp(8'h00);
        cur_req = "R7";
        set_idx(8'h06); wdat(8'h05);
        chk(card_state_o == 2'd3 && csn_o == 8'h05, "R7", "CSN assigned, config", int'(csn_o), 5);
        rdp(8'h00);
        chk(last_rd == 8'h05, "R7", "CSN read back", int'(last_rd), 5);

        // R8/R9: resource bytes, not-ready read, wrap
        cur_req = "R8";
        take_byte(0);
        rdp(8'h00);
        chk(last_rd == 8'h00, "R8", "not-ready read", int'(last_rd), 0);
        for (int i = 1; i <= RES_DEPTH; i++) take_byte(i);

        // R10: logical device select
        cur_req = "R10";
        set_idx(8'h07); wdat(8'h01); rdp(8'h00);
        chk(last_rd == 8'h01, "R10", "ldev read back", int'(last_rd), 1);
        wdat(8'h05); rdp(8'h00);
        chk(last_rd == 8'h01, "R10", "out-of-range ldev ignored", int'(last_rd), 1);

        // R4: bit 0 pulse, write-only index
        cur_req = "R4";
        set_idx(8'h02); wdat(8'h01);
        chk(ldev_reset_o == 1'b1 && csn_o == 8'h05, "R4", "reset pulse, csn kept", int'(ldev_reset_o), 1);
        idle();
        chk(ldev_reset_o == 1'b0, "R4", "pulse ends", int'(ldev_reset_o), 0);
        rdp(8'h00);
        chk(!last_oe, "R4", "control read not driven", int'(last_oe), 0);

        // R5: non-matching wake sleeps; matching nonzero wake configures, rewinds
        cur_req = "R5";
        set_idx(8'h03); wdat(8'h07);
        chk(card_state_o == 2'd1, "R5", "config to sleep", int'(card_state_o), 1);
        wdat(8'h05);
        chk(card_state_o == 2'd3, "R5", "wake 5 configures", int'(card_state_o), 3);
        take_byte(0);

        // R4: bit 1 to dormant keeps CSN; key again; bit 2 clears CSN
        cur_req = "R4";
        set_idx(8'h02); wdat(8'h02);
        chk(card_state_o == 2'd0 && csn_o == 8'h05, "R4", "dormant, csn kept", int'(csn_o), 5);
        cur_req = "R2"; send_key();
        cur_req = "R4";
        set_idx(8'h03); wdat(8'h05);
        set_idx(8'h02); wdat(8'h04);
        chk(csn_o == 8'h00, "R4", "csn cleared", int'(csn_o), 0);

        // R6: lose isolation on a zero bit when the bus shows 0x55
        cur_req = "R6";
        set_idx(8'h03); wdat(8'h00);
        set_idx(8'h01); rdp(8'h55);
        chk(card_state_o == 2'd1, "R6", "lost isolation", int'(card_state_o), 1);
        idle();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule